// File: doc/BRIEF.md
# Key-Gated Scan Chain Scrambler

This block is a set of parallel scan chains whose shift path can be silently corrupted. Every chain is a row of resettable cells. With scan enable low, each cell loads its own functional input. With scan enable high, each chain moves one place toward its scan output on every clock. A handful of designated cells act as an unlock key. During a short injection cycle, their contents are folded into a Galois LFSR. The LFSR's stages drive XOR gates that sit on the shift path in front of chosen cells.

The key itself is not stored anywhere. Each key cell is tapped through either its true or its inverted output, and that choice is fixed when the design is built. A tester who shifts in the right values drives every tap to zero. The LFSR then stays at zero and the chains behave as ordinary scan chains. If even one key cell holds the wrong value, the LFSR becomes nonzero and never returns to zero. From then until reset, data shifted out is scrambled.

An external sequencer supplies two control inputs. The first is an advance enable, which is the only condition under which the LFSR changes. The second is an injection window, which lets key taps into the LFSR while it is advancing.

Top module: `scan_lock_top`

## Requirements
- R1: A synchronous active-low reset clears every scan cell and every LFSR stage, so `func_q` and `scan_out` read zero after reset.
- R2: While `scan_en` is 0, every cell loads its bit of `func_d` on the clock edge. Cell flat index is chain*CHAIN_LEN + column.
- R3: While `scan_en` is 1 and the LFSR is zero, column 0 of chain c loads `scan_in[c]` and column j loads column j-1. `scan_out[c]` is the last column of chain c.
- R4: The default key cells are flat cells 1, 3, 10 and 13, with inversion bits 1, 0, 1, 0 and LFSR stages 0, 5, 9 and 14. A key cell's tap is zero exactly when the cell equals its inversion bit. When every tap is zero, shifting stays intact.
- R5: If any single key cell differs from its inversion bit during an injection cycle, the data shifted out afterwards differs from what a plain shift would give.
- R6: Cells that are not key cells have no effect on the LFSR, whatever value they hold.
- R7: The LFSR changes only when `lfsr_adv` is 1. Key taps enter only when `inj_win` is also 1.
- R8: On an advance, stage 0 takes the last stage XOR its tap. Stage i takes stage i-1, XOR the last stage where polynomial bit i is set, XOR its tap. The default polynomial mask 16'h6800 has bits 11, 13 and 14 set.
- R9: A cell with a path XOR loads its shift source XOR its assigned LFSR stage. The defaults are cell 4 with stage 15, cell 7 with stage 3, cell 11 with stage 8 and cell 14 with stage 15.
- R10: A nonzero LFSR state persists through capture and through further shifting until reset, so later unloads stay scrambled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | 1 shifts the chains, 0 captures functional data |
| scan_in | input | N_CHAINS | Serial input, one per chain |
| func_d | input | N_CHAINS*CHAIN_LEN | Functional data, flat cell order |
| lfsr_adv | input | 1 | Allows the LFSR to advance |
| inj_win | input | 1 | Lets key taps into the LFSR |
| scan_out | output | N_CHAINS | Last cell of each chain |
| func_q | output | N_CHAINS*CHAIN_LEN | Contents of every cell, flat cell order |

## Verification
The bench flips one key cell at a time and expects every unload to be scrambled. A design that dropped a tap, or wired a tap with the wrong polarity, would let a wrong key through or scramble the correct key. It also flips a cell outside the key set, where any difference in the unload means the tap decoding is wrong. Two further cases inject a wrong key with either the advance enable or the window held low; a design that ignored either gate would scramble there. Finally, a second capture after a wrong key must still come out scrambled, and a reset must restore clean shifting, which catches an LFSR that decays or survives reset.

// File: rtl/scan_lock_pkg.sv
// Package: shared constants for the key-gated scan scrambler.
// Assumes every parameter list packs its entries into fields of FW bits.
package scan_lock_pkg;
    localparam int unsigned FW = 8;
    typedef enum logic {CELL_CAPTURE = 1'b0, CELL_SHIFT = 1'b1} cell_mode_e;
endpackage

// File: rtl/scan_chain.sv
// scan_chain: one row of CHAIN_LEN resettable cells.
// Shift mode moves data from si toward q[CHAIN_LEN-1]; each cell's shift
// source is XORed with its flip bit. Capture mode loads func_d.
// Assumes CHAIN_LEN >= 2.
module scan_chain
    import scan_lock_pkg::*;
#(
    parameter int unsigned CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic                 si,
    input  logic [CHAIN_LEN-1:0] func_d,
    input  logic [CHAIN_LEN-1:0] flip,
    output logic [CHAIN_LEN-1:0] q
);
    cell_mode_e mode;

    // Select the cell mode from scan enable.
    always_comb mode = scan_en ? CELL_SHIFT : CELL_CAPTURE;

    // Update all cells: reset, shift with flips, or capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (mode == CELL_SHIFT)
            q <= {q[CHAIN_LEN-2:0], si} ^ flip;
        else
            q <= func_d;
    end
endmodule

// File: rtl/key_inject.sv
// key_inject: turns the key cells into per-stage LFSR injection terms.
// Each key cell is tapped true or inverted, gated by the window, and
// XOR-merged into its assigned stage. Assumes the index and stage fields
// fit the array and LFSR sizes.
module key_inject
    import scan_lock_pkg::*;
#(
    parameter int unsigned N_CELLS  = 16,
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned KEY_COLS = 6,
    parameter int unsigned LFSR_W   = 16,
    parameter int unsigned NKEY     = 4,
    parameter logic [NKEY*FW-1:0] KEY_IDX   = {8'd13, 8'd10, 8'd3, 8'd1},
    parameter logic [NKEY-1:0]    KEY_INV   = 4'b0101,
    parameter logic [NKEY*FW-1:0] KEY_STAGE = {8'd14, 8'd9, 8'd5, 8'd0}
) (
    input  logic [N_CELLS-1:0] cells,
    input  logic               inj_win,
    output logic [LFSR_W-1:0]  inj
);
    localparam int unsigned CW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
    localparam int unsigned SW = (LFSR_W > 1) ? $clog2(LFSR_W) : 1;

    // Elaboration guard: key cells must sit in the first KEY_COLS columns.
    for (genvar p = 0; p < NKEY; p++) begin : g_col_guard
        localparam int unsigned COL = int'(KEY_IDX[p*FW +: FW]) % CHAIN_LEN;
        if (COL >= KEY_COLS) begin : g_bad
            $error("key cell outside the key column range");
        end
    end

    // Build the injection vector from every key tap.
    always_comb begin
        logic [CW-1:0] ci;
        logic [SW-1:0] st;
        inj = '0;
        ci  = '0;
        st  = '0;
        for (int p = 0; p < NKEY; p++) begin
            ci = KEY_IDX[p*FW +: CW];
            st = KEY_STAGE[p*FW +: SW];
            inj[st] = inj[st] ^ (inj_win & (cells[ci] ^ KEY_INV[p]));
        end
    end
endmodule

// File: rtl/obf_lfsr.sv
// obf_lfsr: Galois LFSR that advances only when adv is high and adds the
// injection terms on each advance. Feedback from the last stage enters
// stage 0 and every stage whose POLY bit is set.
module obf_lfsr #(
    parameter int unsigned       LFSR_W = 16,
    parameter logic [LFSR_W-1:0] POLY   = 16'h6800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [LFSR_W-1:0] inj,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] nxt;

    // Next-state function with polynomial feedback and injection.
    always_comb begin
        nxt[0] = state[LFSR_W-1] ^ inj[0];
        for (int i = 1; i < LFSR_W; i++)
            nxt[i] = state[i-1] ^ (POLY[i] & state[LFSR_W-1]) ^ inj[i];
    end

    // State register: cleared on reset, updated only on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '0;
        else if (adv)
            state <= nxt;
    end
endmodule

// File: rtl/path_flip_map.sv
// path_flip_map: routes LFSR stages onto the shift-path XORs of chosen
// cells. Cells without a path XOR get a constant zero flip.
module path_flip_map
    import scan_lock_pkg::*;
#(
    parameter int unsigned N_CELLS = 16,
    parameter int unsigned LFSR_W  = 16,
    parameter int unsigned NOBF    = 4,
    parameter logic [NOBF*FW-1:0] OBF_IDX   = {8'd14, 8'd11, 8'd7, 8'd4},
    parameter logic [NOBF*FW-1:0] OBF_STAGE = {8'd15, 8'd8, 8'd3, 8'd15}
) (
    input  logic [LFSR_W-1:0]  lfsr_q,
    output logic [N_CELLS-1:0] flip
);
    localparam int unsigned CW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
    localparam int unsigned SW = (LFSR_W > 1) ? $clog2(LFSR_W) : 1;

    // Place each selected stage on its target cell's XOR input.
    always_comb begin
        logic [CW-1:0] ci;
        logic [SW-1:0] st;
        flip = '0;
        ci   = '0;
        st   = '0;
        for (int k = 0; k < NOBF; k++) begin
            ci = OBF_IDX[k*FW +: CW];
            st = OBF_STAGE[k*FW +: SW];
            flip[ci] = flip[ci] ^ lfsr_q[st];
        end
    end
endmodule

// File: rtl/scan_lock_top.sv
// scan_lock_top: N_CHAINS scan chains of CHAIN_LEN cells, key taps into an
// LFSR, and LFSR-driven XORs in the shift path. Assumes lfsr_adv and
// inj_win come from an external sequencer.
module scan_lock_top
    import scan_lock_pkg::*;
#(
    parameter int unsigned N_CHAINS  = 2,
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned KEY_COLS  = 6,
    parameter int unsigned LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] POLY = 16'h6800,
    parameter int unsigned NKEY      = 4,
    parameter logic [NKEY*FW-1:0] KEY_IDX   = {8'd13, 8'd10, 8'd3, 8'd1},
    parameter logic [NKEY-1:0]    KEY_INV   = 4'b0101,
    parameter logic [NKEY*FW-1:0] KEY_STAGE = {8'd14, 8'd9, 8'd5, 8'd0},
    parameter int unsigned NOBF      = 4,
    parameter logic [NOBF*FW-1:0] OBF_IDX   = {8'd14, 8'd11, 8'd7, 8'd4},
    parameter logic [NOBF*FW-1:0] OBF_STAGE = {8'd15, 8'd8, 8'd3, 8'd15}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scan_en,
    input  logic [N_CHAINS-1:0]           scan_in,
    input  logic [N_CHAINS*CHAIN_LEN-1:0] func_d,
    input  logic                          lfsr_adv,
    input  logic                          inj_win,
    output logic [N_CHAINS-1:0]           scan_out,
    output logic [N_CHAINS*CHAIN_LEN-1:0] func_q
);
    localparam int unsigned N_CELLS = N_CHAINS * CHAIN_LEN;

    logic [N_CELLS-1:0] cells;
    logic [N_CELLS-1:0] flip_all;
    logic [LFSR_W-1:0]  inj;
    logic [LFSR_W-1:0]  lfsr_q;

    key_inject #(
        .N_CELLS(N_CELLS), .CHAIN_LEN(CHAIN_LEN), .KEY_COLS(KEY_COLS),
        .LFSR_W(LFSR_W), .NKEY(NKEY), .KEY_IDX(KEY_IDX),
        .KEY_INV(KEY_INV), .KEY_STAGE(KEY_STAGE)
    ) u_key (
        .cells(cells), .inj_win(inj_win), .inj(inj)
    );

    obf_lfsr #(.LFSR_W(LFSR_W), .POLY(POLY)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(lfsr_adv), .inj(inj), .state(lfsr_q)
    );

    path_flip_map #(
        .N_CELLS(N_CELLS), .LFSR_W(LFSR_W), .NOBF(NOBF),
        .OBF_IDX(OBF_IDX), .OBF_STAGE(OBF_STAGE)
    ) u_map (
        .lfsr_q(lfsr_q), .flip(flip_all)
    );

    for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
        scan_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
            .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .si(scan_in[c]),
            .func_d(func_d[c*CHAIN_LEN +: CHAIN_LEN]),
            .flip(flip_all[c*CHAIN_LEN +: CHAIN_LEN]),
            .q(cells[c*CHAIN_LEN +: CHAIN_LEN])
        );
        // Serial output is the last column of the chain.
        assign scan_out[c] = cells[c*CHAIN_LEN + CHAIN_LEN - 1];
    end

    assign func_q = cells;
endmodule

// File: rtl/scan_lock_chk.sv
// scan_lock_chk: temporal checks for scan_lock_top, attached by bind.
module scan_lock_chk #(
    parameter int unsigned N_CHAINS  = 2,
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned LFSR_W    = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          scan_en,
    input logic [N_CHAINS-1:0]           scan_in,
    input logic [N_CHAINS*CHAIN_LEN-1:0] func_d,
    input logic                          lfsr_adv,
    input logic                          inj_win,
    input logic [N_CHAINS-1:0]           scan_out,
    input logic [N_CHAINS*CHAIN_LEN-1:0] func_q,
    input logic [LFSR_W-1:0]             lfsr_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lfsr_q == '0 && func_q == '0));

    // R2
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> func_q == $past(func_d));

    // R7
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lfsr_adv |=> $stable(lfsr_q));

    // R7
    closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_adv && !inj_win && lfsr_q == '0) |=> lfsr_q == '0);

    // R8
    lfsr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_adv && !inj_win) |=> lfsr_q[0] == $past(lfsr_q[LFSR_W-1]));

    for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain_chk
        // R3
        scan_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
            scan_en |=> func_q[c*CHAIN_LEN] == $past(scan_in[c]));

        // R3
        scan_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (scan_en && lfsr_q == '0) |=>
                scan_out[c] == $past(func_q[c*CHAIN_LEN + CHAIN_LEN - 2]));
    end
endmodule

bind scan_lock_top scan_lock_chk #(
    .N_CHAINS(N_CHAINS), .CHAIN_LEN(CHAIN_LEN), .LFSR_W(LFSR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_d(func_d), .lfsr_adv(lfsr_adv), .inj_win(inj_win),
    .scan_out(scan_out), .func_q(func_q), .lfsr_q(lfsr_q)
);

// File: tb/tb_scan_lock_top.sv
`timescale 1ns/1ps
// Bench: table of key-load scenarios walked by one loop, then directed
// tests for persistence and reset recovery.
module tb_scan_lock_top;
    localparam int N = 2;
    localparam int M = 8;
    localparam int NC = N * M;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0;
    logic [N-1:0]  scan_in = '0;
    logic [NC-1:0] func_d = '0;
    logic          lfsr_adv = 1'b0;
    logic          inj_win = 1'b0;
    logic [N-1:0]  scan_out;
    logic [NC-1:0] func_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scan_lock_top dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .lfsr_adv(lfsr_adv), .inj_win(inj_win),
        .scan_out(scan_out), .func_q(func_q)
    );

    // Key cell positions and inversion bits from R4.
    localparam int   KIDX [4] = '{1, 3, 10, 13};
    localparam logic KINV [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

    typedef struct packed {
        logic [3:0] key_flip;
        logic       other_flip;
        logic       adv;
        logic       win;
        logic       intact;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'b0000, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 correct key
        '{4'b0001, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 key cell 1 wrong
        '{4'b0010, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 key cell 3 wrong
        '{4'b0100, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 key cell 10 wrong
        '{4'b1000, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 key cell 13 wrong
        '{4'b0000, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 non-key cell flipped
        '{4'b0001, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 no advance
        '{4'b0001, 1'b0, 1'b1, 1'b0, 1'b1}   // R7 window closed
    };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scan_en = 1'b0; lfsr_adv = 1'b0; inj_win = 1'b0;
        scan_in = '0; func_d = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Shift a key pattern in over M cycles with the LFSR frozen.
    task automatic load_key(input logic [3:0] kf, input logic of);
        logic [NC-1:0] pat;
        pat = '0;
        for (int p = 0; p < 4; p++) pat[KIDX[p]] = KINV[p] ^ kf[p];
        pat[0] = pat[0] ^ of;
        for (int t = 0; t < M; t++) begin
            @(negedge clk);
            scan_en = 1'b1; lfsr_adv = 1'b0; inj_win = 1'b0;
            for (int c = 0; c < N; c++) scan_in[c] = pat[c*M + M-1-t];
        end
    endtask

    task automatic capture(input logic a, input logic w, input logic [NC-1:0] fd);
        @(negedge clk);
        scan_en = 1'b0; lfsr_adv = a; inj_win = w; func_d = fd;
    endtask

    // Unload 2*M bits per chain; report capture contents and match flag.
    task automatic unload(input logic [NC-1:0] fd, output logic [NC-1:0] capq,
                          output bit same);
        logic expb;
        same = 1'b1;
        capq = '0;
        for (int k = 0; k < 2*M; k++) begin
            @(negedge clk);
            if (k == 0) capq = func_q;
            for (int c = 0; c < N; c++) begin
                expb = (k < M) ? fd[c*M + M-1-k] : 1'b0;
                if (scan_out[c] !== expb) same = 1'b0;
            end
            scan_en = 1'b1; lfsr_adv = 1'b1; inj_win = 1'b0; scan_in = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] fd;
        logic [NC-1:0] capq;
        bit same;

        // R1 reset state
        do_reset();
        check(func_q == '0 && scan_out == '0, "R1 reset state",
              {func_q, scan_out}, 64'd0);

        for (int i = 0; i < 8; i++) begin
            fd = 16'h5A3C ^ 16'(i * 16'h1357);
            do_reset();
            load_key(VECS[i].key_flip, VECS[i].other_flip);
            capture(VECS[i].adv, VECS[i].win, fd);
            unload(fd, capq, same);
            check(capq == fd, "R2 capture", capq, fd);
            if (VECS[i].intact)
                check(same, "R3 R4 R6 R7 unload intact", {63'd0, same}, 64'd1);
            else
                check(!same, "R5 R8 R9 unload scrambled", {63'd0, same}, 64'd0);
        end

        // R10: wrong key, then a second capture still comes out scrambled
        do_reset();
        load_key(4'b0001, 1'b0);
        fd = 16'hC3A5;
        capture(1'b1, 1'b1, fd);
        unload(fd, capq, same);
        check(!same, "R10 first unload scrambled", {63'd0, same}, 64'd0);
        fd = 16'h0FF0;
        capture(1'b1, 1'b0, fd);
        unload(fd, capq, same);
        check(capq == fd, "R2 recapture after wrong key", capq, fd);
        check(!same, "R10 second unload still scrambled", {63'd0, same}, 64'd0);

        // R1: reset after scrambling restores clean state and clean shifting
        do_reset();
        check(func_q == '0 && scan_out == '0, "R1 reset after scramble",
              {func_q, scan_out}, 64'd0);
        load_key(4'b0000, 1'b0);
        fd = 16'hFFFF;
        capture(1'b1, 1'b1, fd);
        unload(fd, capq, same);
        check(same, "R1 R4 clean unload after reset", {63'd0, same}, 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule